// File: doc/BRIEF.md
# Hypervisor Interrupt Delegation Masking

This block keeps the hypervisor's interrupt delegation register and the hypervisor's own interrupt-pending and interrupt-enable registers for a hart that runs guests. It takes the machine-level delegation register and the machine virtual-interrupt enable register as inputs and returns legal read values for four registers: machine delegation, hypervisor delegation, hypervisor pending and hypervisor enable.

Writes come from one CSR write port. There is one decoded enable per hypervisor register and a shared data word. A write changes only the bits that are legal at the moment of the write. Every read passes through a mask that follows the current machine-level settings. A stored bit can therefore be hidden and later shown again without being rewritten. Reads are combinational. A write becomes visible on the cycle after the clock edge that takes it.

Top module: `hyp_irq_deleg`

## Requirements
- R1: `rd_mdeleg` equals `mdeleg_in` with bits 2, 6 and 10 (the guest software, timer and external interrupt positions) forced to one.
- R2: Any bit that is zero in `rd_mdeleg` reads as zero in `rd_hdeleg`, `rd_hpend` and `rd_hie`.
- R3: `rd_hdeleg` is zero at every position other than 2, 6, 10 and 13. None of its bits ever reads as a constant one, so after reset even positions 2, 6 and 10 read zero.
- R4: Bit 13 (local counter overflow) of the hypervisor delegation register is read/write when bit 13 of `mdeleg_in` is set, and it resets to zero.
- R5: A write to the hypervisor delegation register stores data only at positions 2, 6, 10 and 13 where `rd_mdeleg | mvien_in` is one. Every other stored bit keeps its value. A bit stored this way while only `mvien_in` allowed it reads as zero until `mdeleg_in` sets that bit.
- R6: Read masking is reversible. A stored bit 13 reads zero while `mdeleg_in[13]` is clear, and it reads its stored value again once that bit is set, with no write in between.
- R7: Writes to the pending and enable registers store data only at positions 2, 6, 10 and 13 where `rd_mdeleg` is one. All other stored bits are left unchanged.
- R8: After reset, `rd_hdeleg`, `rd_hpend` and `rd_hie` read zero.
- R9: A write is visible on the cycle after its clock edge. With no write enable asserted, the stored values do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_deleg_en | input | 1 | Write strobe for the hypervisor delegation register |
| wr_pend_en | input | 1 | Write strobe for the hypervisor pending register |
| wr_ie_en | input | 1 | Write strobe for the hypervisor enable register |
| wr_data | input | XLEN | Shared write data |
| mdeleg_in | input | XLEN | Machine delegation register contents |
| mvien_in | input | XLEN | Machine virtual-interrupt enable contents |
| rd_mdeleg | output | XLEN | Legal read value of machine delegation |
| rd_hdeleg | output | XLEN | Legal read value of hypervisor delegation |
| rd_hpend | output | XLEN | Legal read value of hypervisor pending |
| rd_hie | output | XLEN | Legal read value of hypervisor enable |

## Verification
A wrong stored bit appears on the read port in the cycle after the write that caused it, but only while the machine-level bits allow that bit to be seen. A corrupted bit 13 that sits behind a cleared machine bit stays hidden until `mdeleg_in[13]` is set. For this reason the stimulus keeps toggling the controlling machine bits after each write, and it reads every register in both the hidden and the shown state. A pseudo-random phase mixes writes with changes to the control inputs and compares all four read values against a model built from the requirements.

// File: rtl/hyp_irq_deleg_pkg.sv
package hyp_irq_deleg_pkg;
  localparam int GUEST_SW_BIT  = 2;
  localparam int GUEST_TMR_BIT = 6;
  localparam int GUEST_EXT_BIT = 10;
  localparam int CNT_OVF_BIT   = 13;
  localparam int NUM_FIELDS    = 3;

  typedef enum logic [1:0] {
    FLD_DELEG = 2'd0,
    FLD_PEND  = 2'd1,
    FLD_IE    = 2'd2
  } field_e;
endpackage

// File: rtl/hyp_irq_mask_gen.sv
module hyp_irq_mask_gen
  import hyp_irq_deleg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] mdeleg_in,
  input  logic [XLEN-1:0] mvien_in,
  output logic [XLEN-1:0] mdeleg_view,
  output logic [XLEN-1:0] deleg_wmask,
  output logic [XLEN-1:0] deleg_rmask,
  output logic [XLEN-1:0] local_wmask,
  output logic [XLEN-1:0] local_rmask
);
  localparam logic [XLEN-1:0] GUEST_MASK =
    (XLEN'(1) << GUEST_SW_BIT) | (XLEN'(1) << GUEST_TMR_BIT) |
    (XLEN'(1) << GUEST_EXT_BIT);
  localparam logic [XLEN-1:0] STORE_MASK = GUEST_MASK | (XLEN'(1) << CNT_OVF_BIT);

  always_comb begin
    mdeleg_view = mdeleg_in | GUEST_MASK;
    // Delegation may be written where either machine control allows it.
    deleg_wmask = STORE_MASK & (mdeleg_view | mvien_in);
    // It is shown only where the machine delegation bit is set.
    deleg_rmask = STORE_MASK & mdeleg_view;
    local_wmask = STORE_MASK & mdeleg_view;
    local_rmask = STORE_MASK & mdeleg_view;
  end
endmodule

// File: rtl/hyp_irq_field_reg.sv
module hyp_irq_field_reg #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic [XLEN-1:0] wmask,
  input  logic [XLEN-1:0] rmask,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] store_q;
  logic [XLEN-1:0] store_d;
  logic            store_ce;

  always_comb begin
    store_ce = wr_en;
    store_d  = (store_q & ~wmask) | (wr_data & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        store_q <= '0;
    else if (store_ce) store_q <= store_d;
  end

  assign rdata = store_q & rmask;

  // R5
  keep_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((store_q ^ $past(store_q)) & ~$past(wmask)) == '0));
  // R5
  take_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((store_q ^ $past(wr_data)) & $past(wmask)) == '0));
  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(store_q));
endmodule

// File: rtl/hyp_irq_deleg.sv
module hyp_irq_deleg
  import hyp_irq_deleg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_deleg_en,
  input  logic            wr_pend_en,
  input  logic            wr_ie_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic [XLEN-1:0] mdeleg_in,
  input  logic [XLEN-1:0] mvien_in,
  output logic [XLEN-1:0] rd_mdeleg,
  output logic [XLEN-1:0] rd_hdeleg,
  output logic [XLEN-1:0] rd_hpend,
  output logic [XLEN-1:0] rd_hie
);
  localparam logic [XLEN-1:0] DELEG_SHOW_MAX =
    (XLEN'(1) << GUEST_SW_BIT) | (XLEN'(1) << GUEST_TMR_BIT) |
    (XLEN'(1) << GUEST_EXT_BIT) | (XLEN'(1) << CNT_OVF_BIT);

  logic [XLEN-1:0] deleg_wmask, deleg_rmask, local_wmask, local_rmask;
  logic [NUM_FIELDS-1:0] fld_we;
  logic [XLEN-1:0] fld_wmask [NUM_FIELDS];
  logic [XLEN-1:0] fld_rmask [NUM_FIELDS];
  logic [XLEN-1:0] fld_rd    [NUM_FIELDS];

  hyp_irq_mask_gen #(.XLEN(XLEN)) u_mask (
    .mdeleg_in   (mdeleg_in),
    .mvien_in    (mvien_in),
    .mdeleg_view (rd_mdeleg),
    .deleg_wmask (deleg_wmask),
    .deleg_rmask (deleg_rmask),
    .local_wmask (local_wmask),
    .local_rmask (local_rmask)
  );

  always_comb begin
    fld_we[FLD_DELEG] = wr_deleg_en;
    fld_we[FLD_PEND]  = wr_pend_en;
    fld_we[FLD_IE]    = wr_ie_en;
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    if (g == int'(FLD_DELEG)) begin : g_deleg
      assign fld_wmask[g] = deleg_wmask;
      assign fld_rmask[g] = deleg_rmask;
    end else begin : g_local
      assign fld_wmask[g] = local_wmask;
      assign fld_rmask[g] = local_rmask;
    end
    hyp_irq_field_reg #(.XLEN(XLEN)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (fld_we[g]),
      .wr_data (wr_data),
      .wmask   (fld_wmask[g]),
      .rmask   (fld_rmask[g]),
      .rdata   (fld_rd[g])
    );
  end

  assign rd_hdeleg = fld_rd[FLD_DELEG];
  assign rd_hpend  = fld_rd[FLD_PEND];
  assign rd_hie    = fld_rd[FLD_IE];

  // R2
  deleg_follows_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hdeleg & ~rd_mdeleg) == '0);
  // R2
  local_follows_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_hpend | rd_hie) & ~rd_mdeleg) == '0);
  // R3
  deleg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hdeleg & ~DELEG_SHOW_MAX) == '0);
  // R6
  reveal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_deleg_en && $rose(mdeleg_in[CNT_OVF_BIT])) |=>
      (rd_hdeleg[CNT_OVF_BIT] == 1'b0 || mdeleg_in[CNT_OVF_BIT]));
endmodule

// File: tb/hyp_irq_deleg_bench.sv
module hyp_irq_deleg_bench;
  localparam int XLEN = 64;
  localparam logic [63:0] GM  = 64'h444;
  localparam logic [63:0] SM  = 64'h2444;
  localparam logic [63:0] B13 = 64'h2000;

  typedef struct packed {
    logic [63:0] md;
    logic [63:0] hd;
    logic [63:0] hp;
    logic [63:0] he;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_deleg_en, wr_pend_en, wr_ie_en;
  logic [63:0] wr_data, mdeleg_in, mvien_in;
  logic [63:0] rd_mdeleg, rd_hdeleg, rd_hpend, rd_hie;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t  exp_q[$];
  string tag_q[$];
  logic [63:0] m_hd = '0, m_hp = '0, m_he = '0;

  always #5 clk = ~clk;

  hyp_irq_deleg #(.XLEN(XLEN)) u_hyp_irq_deleg (
    .clk(clk), .rst_n(rst_n),
    .wr_deleg_en(wr_deleg_en), .wr_pend_en(wr_pend_en), .wr_ie_en(wr_ie_en),
    .wr_data(wr_data), .mdeleg_in(mdeleg_in), .mvien_in(mvien_in),
    .rd_mdeleg(rd_mdeleg), .rd_hdeleg(rd_hdeleg),
    .rd_hpend(rd_hpend), .rd_hie(rd_hie)
  );

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares queued expectations at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp(t, "mdeleg R1", rd_mdeleg, e.md);
        cmp(t, "hdeleg", rd_hdeleg, e.hd);
        cmp(t, "hpend", rd_hpend, e.hp);
        cmp(t, "hie", rd_hie, e.he);
      end
    end
  end

  function automatic exp_t predict(logic [63:0] md);
    exp_t e;
    logic [63:0] vis;
    vis  = md | GM;
    e.md = vis;
    e.hd = m_hd & SM & vis;
    e.hp = m_hp & SM & vis;
    e.he = m_he & SM & vis;
    return e;
  endfunction

  // Driver: applies one cycle of stimulus, updates the model, queues the result.
  task automatic step(logic [63:0] md, logic [63:0] mv, logic [2:0] we,
                      logic [63:0] wd, string tag);
    logic [63:0] vis;
    @(posedge clk); #2;
    mdeleg_in = md; mvien_in = mv; wr_data = wd;
    wr_deleg_en = we[0]; wr_pend_en = we[1]; wr_ie_en = we[2];
    vis = md | GM;
    if (we[0]) m_hd = (m_hd & ~(SM & (vis | mv))) | (wd & SM & (vis | mv));
    if (we[1]) m_hp = (m_hp & ~(SM & vis)) | (wd & SM & vis);
    if (we[2]) m_he = (m_he & ~(SM & vis)) | (wd & SM & vis);
    @(posedge clk); #2;
    wr_deleg_en = 1'b0; wr_pend_en = 1'b0; wr_ie_en = 1'b0;
    exp_q.push_back(predict(md));
    tag_q.push_back(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] lfsr;
    rst_n = 1'b0;
    wr_deleg_en = 1'b0; wr_pend_en = 1'b0; wr_ie_en = 1'b0;
    wr_data = '0; mdeleg_in = '0; mvien_in = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R8 reset state, R1 forced ones
    step('0, '0, 3'b000, '0, "R8");
    // R3 only 2,6,10 writable with no machine bits
    step('0, '0, 3'b001, '1, "R3");
    // R4 counter-overflow bit writable when machine delegation sets it
    step(B13, '0, 3'b001, '1, "R4");
    // R6 hidden then shown again
    step('0, '0, 3'b000, '0, "R6");
    step(B13, '0, 3'b000, '0, "R6");
    // R5 write while bit 13 illegal leaves stored bit 13
    step('0, '0, 3'b001, '0, "R5");
    step(B13, '0, 3'b000, '0, "R5");
    // R5 machine virtual enable makes bit 13 writable but still hidden
    step('0, B13, 3'b001, '0, "R5");
    step(B13, '0, 3'b000, '0, "R5");
    step('0, B13, 3'b001, '1, "R5");
    step(B13, '0, 3'b000, '0, "R5");
    // R7 pending and enable
    step('0, B13, 3'b110, '1, "R7");
    step(B13, '0, 3'b000, '0, "R7");
    step(B13, '0, 3'b110, 64'hFFFF_FFFF_FFFF_DBBB, "R7");
    step(B13, '0, 3'b100, '1, "R7");
    step('0, '0, 3'b000, '0, "R2");
    // R9 idle cycles with data toggling
    step(B13, '1, 3'b000, '1, "R9");
    step(B13, '1, 3'b000, '0, "R9");
    // R2 mixed pseudo-random traffic
    lfsr = 64'hACE1_2345_6789_BEEF;
    for (int i = 0; i < 60; i++) begin
      logic [63:0] md, mv, wd;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      md = {lfsr[31:0], lfsr[63:32]};
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      mv = lfsr ^ 64'h5555;
      wd = ~lfsr;
      step(md, mv, lfsr[2:0], wd, "R2");
    end
    @(posedge clk);
    @(negedge clk);
    #1;
    finish_run();
  end
endmodule